// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Channel Synthesizer

This block is the programming port of a two-channel frequency synthesizer. A controller sends 22-bit words over three wires: a serial clock, a data line and a load strobe. Every rising edge of the serial clock shifts one data bit in, most significant bit first. A rising edge of the load strobe copies the upper 20 bits of the word into one of four configuration registers. The two bits shifted in last choose the register. All three serial inputs are oversampled and synchronised into the system clock domain, so the whole block runs on one clock.

The four registers hold the reference and feedback settings of the high-band (main) channel and of the low-band (auxiliary) channel. Their fields come out as parallel outputs:

- reference divide value, detector polarity, pump current select, pump tri-state and two output-mode bits;
- swallow count, main count, prescaler select and power-down;
- the prescaler modulus that the select bit implies.

Two combinations of the output-mode bits act as counter-reset commands for one channel or for both. A sticky flag records any attempt to program a reference divide value below two.

Top module: `synth_cfg_port`

## Requirements
- R1: On each rising edge of `ser_clk` the 22-bit shift word moves up one place and takes `ser_dat` into bit 0, so the first bit sent ends in bit 21. When more than 22 bits are sent before a load, only the last 22 are kept.
- R2: A rising edge of `ser_le` writes word bits [21:2] into the register chosen by bits [1:0]. The choices are 00 auxiliary reference, 01 auxiliary feedback, 10 main reference and 11 main feedback. The other three registers keep their contents.
- R3: Reference register fields, by word bit position:
  - [16:2] divide value;
  - 17 detector polarity;
  - 18 4x current select;
  - 19 pump tri-state;
  - 20 output-mode bit `mode[0]`;
  - 21 output-mode bit `mode[1]`.
- R4: Feedback register fields, by word bit position:
  - [6:2] swallow count A;
  - [19:7] count B;
  - 20 prescaler select;
  - 21 power-down.
- R5: The prescaler modulus output is the lower modulus when the select bit is 0 and the higher one when it is 1. On the main channel these are 16 and 32. On the auxiliary channel they are 8 and 16.
- R6: Each load produces exactly one system-clock cycle of `wr_stb`. That pulse has only the bit of the addressed register set (bit n for address n), and it comes in the same cycle as the register update.
- R7: After `rst_n` is asserted, all four registers, `wr_stb` and the bad-divide flag read zero. Both modulus outputs then show the lower modulus.
- R8: A reference write whose divide value is 0 or 1 still stores that value and sets `r_div_bad`. The flag stays set through later legal writes until reset.
- R9: `aux_cnt_rst` is 1 exactly when `main_mode[1]`, `aux_mode[1]` and `aux_mode[0]` are all 1.
- R10: `main_cnt_rst` is 1 exactly when `main_mode[1]`, `aux_mode[1]` and `main_mode[0]` are all 1. When all four mode bits are set, both requests are active.
- R11: Shifting and loading work normally while either channel's power-down bit is set.
- R12: The shift word is not cleared by a load. A second load strobe with no serial clocks in between writes the same word again, to the same register, with a new strobe.

Tie-off note: `rst_n` is asynchronous and active low. Software must not program a reference divide value below 2; `r_div_bad` reports when it happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (oversampled) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on its rising edge |
| wr_stb | output | 4 | One-cycle write pulse, one bit per register |
| aux_r_div | output | 15 | Auxiliary reference divide value |
| aux_pd_pol | output | 1 | Auxiliary detector polarity |
| aux_cp_4x | output | 1 | Auxiliary 4x pump current select |
| aux_cp_tri | output | 1 | Auxiliary pump tri-state |
| aux_mode | output | 2 | Auxiliary output-mode bits |
| main_r_div | output | 15 | Main reference divide value |
| main_pd_pol | output | 1 | Main detector polarity |
| main_cp_4x | output | 1 | Main 4x pump current select |
| main_cp_tri | output | 1 | Main pump tri-state |
| main_mode | output | 2 | Main output-mode bits |
| aux_a | output | 5 | Auxiliary swallow count |
| aux_b | output | 13 | Auxiliary count B |
| aux_psel | output | 1 | Auxiliary prescaler select |
| aux_pwdn | output | 1 | Auxiliary power-down |
| aux_pmod | output | 6 | Auxiliary prescaler modulus (8 or 16) |
| main_a | output | 5 | Main swallow count |
| main_b | output | 13 | Main count B |
| main_psel | output | 1 | Main prescaler select |
| main_pwdn | output | 1 | Main power-down |
| main_pmod | output | 6 | Main prescaler modulus (16 or 32) |
| aux_cnt_rst | output | 1 | Auxiliary counter reset request |
| main_cnt_rst | output | 1 | Main counter reset request |
| r_div_bad | output | 1 | Sticky flag: reference divide below 2 written |

## Verification
A table of words is loaded first. It visits every address with field values chosen so that no two fields share a pattern. A bit that lands in the wrong field, or a write that goes to the wrong register, therefore shows up in the shadow comparison that follows every load. The same table runs through the four combinations of output-mode bits that separate "no request", auxiliary only, main only and both reset requests. Directed loads follow:

- a word sent with surplus leading bits, which tells a 22-bit window apart from a longer one;
- a bare load strobe, which tells a cleared shift word apart from a kept one;
- a divide value of 1 and then a legal one, which tests that the bad-divide flag is sticky;
- writes made while a channel is powered down.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W   = 22;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = WORD_W - ADDR_W;
  localparam int NREG     = 1 << ADDR_W;
  localparam int RDIV_W   = 15;
  localparam int A_W      = 5;
  localparam int B_W      = 13;
  localparam int PMOD_W   = 6;
  localparam int RDIV_MIN = 2;

  // register select codes: the address decode depends on these values
  typedef enum logic [ADDR_W-1:0] {
    SEL_AUX_REF  = 2'b00,
    SEL_AUX_FB   = 2'b01,
    SEL_MAIN_REF = 2'b10,
    SEL_MAIN_FB  = 2'b11
  } sel_e;

  typedef struct packed {
    logic [1:0]        mode;
    logic              tri_st;
    logic              x4;
    logic              pol;
    logic [RDIV_W-1:0] div;
  } ref_t;

  typedef struct packed {
    logic           pwdn;
    logic           psel;
    logic [B_W-1:0] b;
    logic [A_W-1:0] a;
  } fb_t;

  function automatic logic [PMOD_W-1:0] pmod_of(input logic psel, input logic high_band);
    logic [PMOD_W-1:0] base;
    base = high_band ? PMOD_W'(16) : PMOD_W'(8);
    return psel ? PMOD_W'(base << 1) : base;
  endfunction

  function automatic logic div_is_bad(input logic [RDIV_W-1:0] d);
    return d < RDIV_W'(RDIV_MIN);
  endfunction

  // a channel's counter reset: its own mode is 11 and the other side's high bit is set
  function automatic logic cnt_rst_req(input logic [1:0] own, input logic [1:0] other);
    return own[1] & own[0] & other[1];
  endfunction

  function automatic logic is_ref_sel(input logic [ADDR_W-1:0] s);
    return (s == SEL_AUX_REF) || (s == SEL_MAIN_REF);
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in[g]};
    end
    assign d_out[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[W-2:0], din};
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [WORD_W-1:0]          word,
  output logic [NREG-1:0][DATA_W-1:0] regs,
  output logic [NREG-1:0]            wr_stb,
  output logic                       div_bad
);
  logic [ADDR_W-1:0] sel;
  logic [DATA_W-1:0] data;
  logic [NREG-1:0]   we;
  logic              bad_now;

  assign sel     = word[ADDR_W-1:0];
  assign data    = word[WORD_W-1:ADDR_W];
  assign bad_now = load && is_ref_sel(sel) && div_is_bad(data[RDIV_W-1:0]);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign we[g] = load && (sel == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[g] <= '0;
      else if (we[g]) regs[g] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= '0;
      div_bad <= 1'b0;
    end else begin
      wr_stb <= we;
      if (bad_now) div_bad <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_chan_decode.sv
module cfg_chan_decode
  import cfg_pkg::*;
#(
  parameter bit HIGH_BAND = 1'b0
) (
  input  ref_t              r,
  input  fb_t               f,
  output logic [RDIV_W-1:0] r_div,
  output logic              pd_pol,
  output logic              cp_4x,
  output logic              cp_tri,
  output logic [1:0]        mode,
  output logic [A_W-1:0]    a,
  output logic [B_W-1:0]    b,
  output logic              psel,
  output logic              pwdn,
  output logic [PMOD_W-1:0] pmod
);
  assign r_div  = r.div;
  assign pd_pol = r.pol;
  assign cp_4x  = r.x4;
  assign cp_tri = r.tri_st;
  assign mode   = r.mode;
  assign a      = f.a;
  assign b      = f.b;
  assign psel   = f.psel;
  assign pwdn   = f.pwdn;
  assign pmod   = pmod_of(f.psel, HIGH_BAND);
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  output logic [NREG-1:0]   wr_stb,
  output logic [RDIV_W-1:0] aux_r_div,
  output logic              aux_pd_pol,
  output logic              aux_cp_4x,
  output logic              aux_cp_tri,
  output logic [1:0]        aux_mode,
  output logic [RDIV_W-1:0] main_r_div,
  output logic              main_pd_pol,
  output logic              main_cp_4x,
  output logic              main_cp_tri,
  output logic [1:0]        main_mode,
  output logic [A_W-1:0]    aux_a,
  output logic [B_W-1:0]    aux_b,
  output logic              aux_psel,
  output logic              aux_pwdn,
  output logic [PMOD_W-1:0] aux_pmod,
  output logic [A_W-1:0]    main_a,
  output logic [B_W-1:0]    main_b,
  output logic              main_psel,
  output logic              main_pwdn,
  output logic [PMOD_W-1:0] main_pmod,
  output logic              aux_cnt_rst,
  output logic              main_cnt_rst,
  output logic              r_div_bad
);
  logic [2:0]                 s_lvl;
  logic [1:0]                 prev_q;
  logic                       dat_s;
  logic                       clk_rise;
  logic                       le_rise;
  logic [WORD_W-1:0]          sr_word;
  logic [NREG-1:0][DATA_W-1:0] regs_q;
  ref_t                       aux_ref, main_ref;
  fb_t                        aux_fb, main_fb;

  cfg_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ser_le, ser_clk, ser_dat}),
    .d_out (s_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= s_lvl[2:1];
  end

  assign dat_s    = s_lvl[0];
  assign clk_rise = s_lvl[1] & ~prev_q[0];
  assign le_rise  = s_lvl[2] & ~prev_q[1];

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (clk_rise),
    .din      (dat_s),
    .word     (sr_word)
  );

  cfg_regbank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (le_rise),
    .word    (sr_word),
    .regs    (regs_q),
    .wr_stb  (wr_stb),
    .div_bad (r_div_bad)
  );

  assign aux_ref  = ref_t'(regs_q[SEL_AUX_REF]);
  assign aux_fb   = fb_t'(regs_q[SEL_AUX_FB]);
  assign main_ref = ref_t'(regs_q[SEL_MAIN_REF]);
  assign main_fb  = fb_t'(regs_q[SEL_MAIN_FB]);

  cfg_chan_decode #(.HIGH_BAND(1'b0)) u_aux_dec (
    .r(aux_ref), .f(aux_fb),
    .r_div(aux_r_div), .pd_pol(aux_pd_pol), .cp_4x(aux_cp_4x), .cp_tri(aux_cp_tri),
    .mode(aux_mode), .a(aux_a), .b(aux_b), .psel(aux_psel), .pwdn(aux_pwdn),
    .pmod(aux_pmod)
  );

  cfg_chan_decode #(.HIGH_BAND(1'b1)) u_main_dec (
    .r(main_ref), .f(main_fb),
    .r_div(main_r_div), .pd_pol(main_pd_pol), .cp_4x(main_cp_4x), .cp_tri(main_cp_tri),
    .mode(main_mode), .a(main_a), .b(main_b), .psel(main_psel), .pwdn(main_pwdn),
    .pmod(main_pmod)
  );

  assign aux_cnt_rst  = cnt_rst_req(aux_ref.mode, main_ref.mode);
  assign main_cnt_rst = cnt_rst_req(main_ref.mode, aux_ref.mode);
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk
  import cfg_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       le_rise,
  input logic                       clk_rise,
  input logic                       dat_s,
  input logic [WORD_W-1:0]          sr_word,
  input logic [NREG-1:0]            wr_stb,
  input logic [NREG-1:0][DATA_W-1:0] regs_q,
  input logic                       r_div_bad
);
  // R1: a serial clock edge moves the word up and takes in the sampled bit
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> (sr_word == {$past(sr_word[WORD_W-2:0]), $past(dat_s)}));

  // R2: registers change only in a cycle that carries a write strobe
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb == '0) |-> $stable(regs_q));

  // R6: at most one strobe bit at a time
  p_stb_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  // R6: a strobe always follows a detected load edge
  p_stb_after_le_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb != '0) |-> $past(le_rise));

  // R8: a low auxiliary reference divide write raises the flag
  p_bad_div_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[SEL_AUX_REF] && (regs_q[SEL_AUX_REF][RDIV_W-1:0] < RDIV_W'(RDIV_MIN))) |-> r_div_bad);

  // R8: the flag is sticky
  p_bad_div_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_div_bad |=> r_div_bad);
endmodule

bind synth_cfg_port synth_cfg_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .le_rise   (le_rise),
  .clk_rise  (clk_rise),
  .dat_s     (dat_s),
  .sr_word   (sr_word),
  .wr_stb    (wr_stb),
  .regs_q    (regs_q),
  .r_div_bad (r_div_bad)
);

// File: tb/synth_cfg_port_tb_top.sv
`timescale 1ns/1ps
module synth_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;

  logic [3:0]  wr_stb;
  logic [14:0] aux_r_div, main_r_div;
  logic        aux_pd_pol, aux_cp_4x, aux_cp_tri, main_pd_pol, main_cp_4x, main_cp_tri;
  logic [1:0]  aux_mode, main_mode;
  logic [4:0]  aux_a, main_a;
  logic [12:0] aux_b, main_b;
  logic        aux_psel, aux_pwdn, main_psel, main_pwdn;
  logic [5:0]  aux_pmod, main_pmod;
  logic        aux_cnt_rst, main_cnt_rst, r_div_bad;

  always #2 clk = ~clk;

  synth_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .wr_stb(wr_stb),
    .aux_r_div(aux_r_div), .aux_pd_pol(aux_pd_pol), .aux_cp_4x(aux_cp_4x),
    .aux_cp_tri(aux_cp_tri), .aux_mode(aux_mode),
    .main_r_div(main_r_div), .main_pd_pol(main_pd_pol), .main_cp_4x(main_cp_4x),
    .main_cp_tri(main_cp_tri), .main_mode(main_mode),
    .aux_a(aux_a), .aux_b(aux_b), .aux_psel(aux_psel), .aux_pwdn(aux_pwdn), .aux_pmod(aux_pmod),
    .main_a(main_a), .main_b(main_b), .main_psel(main_psel), .main_pwdn(main_pwdn),
    .main_pmod(main_pmod),
    .aux_cnt_rst(aux_cnt_rst), .main_cnt_rst(main_cnt_rst), .r_div_bad(r_div_bad)
  );

  // word builders: data field above a 2-bit register select
  function automatic logic [21:0] mkref(input logic [1:0] md, input logic tr, input logic x4,
                                        input logic pol, input logic [14:0] dv, input logic [1:0] sel);
    return {md, tr, x4, pol, dv, sel};
  endfunction
  function automatic logic [21:0] mkfb(input logic pd, input logic ps, input logic [12:0] bb,
                                       input logic [4:0] aa, input logic [1:0] sel);
    return {pd, ps, bb, aa, sel};
  endfunction

  // {word, expected strobe}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {mkref(2'b00, 1'b0, 1'b1, 1'b1, 15'd100,    2'b00), 4'b0001},
    {mkfb (1'b0, 1'b1, 13'd300,  5'd17,         2'b01), 4'b0010},
    {mkref(2'b00, 1'b1, 1'b0, 1'b0, 15'h7FFF,   2'b10), 4'b0100},
    {mkfb (1'b1, 1'b0, 13'h1FFF, 5'd31,         2'b11), 4'b1000},
    {mkref(2'b11, 1'b0, 1'b0, 1'b1, 15'd2,      2'b00), 4'b0001},
    {mkref(2'b10, 1'b0, 1'b1, 1'b0, 15'd3,      2'b10), 4'b0100},
    {mkref(2'b11, 1'b1, 1'b1, 1'b1, 15'h2AAA,   2'b10), 4'b0100},
    {mkref(2'b10, 1'b1, 1'b0, 1'b0, 15'h5555,   2'b00), 4'b0001},
    {mkfb (1'b0, 1'b1, 13'h0AAA, 5'd9,          2'b11), 4'b1000}
  };

  int n_tests = 0, n_fail = 0;
  int stb_cnt = 0;
  logic [3:0] stb_or = '0;
  logic [19:0] sh [4];
  logic exp_bad = 1'b0;

  always @(negedge clk) if (wr_stb != 4'b0) begin
    stb_cnt = stb_cnt + 1;
    stb_or  = stb_or | wr_stb;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] am, mm;
    am = sh[0][19:18];
    mm = sh[2][19:18];
    chk(req, "aux ref fields (R3)", {aux_mode, aux_cp_tri, aux_cp_4x, aux_pd_pol, aux_r_div}, sh[0]);
    chk(req, "aux fb fields (R4)", {aux_pwdn, aux_psel, aux_b, aux_a}, sh[1]);
    chk(req, "main ref fields (R3)", {main_mode, main_cp_tri, main_cp_4x, main_pd_pol, main_r_div}, sh[2]);
    chk(req, "main fb fields (R4)", {main_pwdn, main_psel, main_b, main_a}, sh[3]);
    chk(req, "aux modulus (R5)", aux_pmod, sh[1][18] ? 32'd16 : 32'd8);
    chk(req, "main modulus (R5)", main_pmod, sh[3][18] ? 32'd32 : 32'd16);
    chk(req, "aux reset req (R9)", aux_cnt_rst, am[1] && am[0] && mm[1]);
    chk(req, "main reset req (R10)", main_cnt_rst, mm[1] && mm[0] && am[1]);
    chk(req, "bad divide flag (R8)", r_div_bad, exp_bad);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); ser_dat = v[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le(input logic [21:0] w, input logic [3:0] exp_stb, input string req);
    @(negedge clk);
    stb_cnt = 0; stb_or = '0;
    ser_le = 1'b1;
    repeat (6) @(negedge clk);
    ser_le = 1'b0;
    repeat (8) @(negedge clk);
    sh[w[1:0]] = w[21:2];
    if ((w[1:0] == 2'b00 || w[1:0] == 2'b10) && w[16:2] < 15'd2) exp_bad = 1'b1;
    chk(req, "strobe cycles (R6)", stb_cnt, 1);
    chk(req, "strobe bit (R2/R6)", stb_or, exp_stb);
    check_all(req);
  endtask

  task automatic send(input logic [21:0] w, input string req);
    shift_bits({10'b0, w}, 22);
    pulse_le(w, 4'b0001 << w[1:0], req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [21:0] w;
    for (int i = 0; i < 4; i++) sh[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7: reset state
    check_all("R7");
    chk("R7", "strobe idle", wr_stb, 0);

    // table walk: R1, R2, R3, R4, R5, R6, R9, R10
    for (int v = 0; v < NV; v++) begin
      shift_bits({10'b0, VEC[v][25:4]}, 22);
      pulse_le(VEC[v][25:4], VEC[v][3:0], "R2");
    end

    // R11: main channel powered down, then further writes still land
    send(mkfb(1'b1, 1'b1, 13'd77, 5'd4, 2'b11), "R11");
    send(mkref(2'b01, 1'b1, 1'b1, 1'b0, 15'd999, 2'b10), "R11");
    send(mkfb(1'b1, 1'b0, 13'd55, 5'd3, 2'b01), "R11");
    send(mkref(2'b00, 1'b0, 1'b0, 1'b1, 15'd1234, 2'b00), "R11");

    // R1: surplus leading bits are pushed out; only the last 22 stay
    w = mkfb(1'b0, 1'b1, 13'd4000, 5'd21, 2'b01);
    shift_bits({7'b0, 3'b110, w}, 25);
    pulse_le(w, 4'b0010, "R1");

    // R12: a bare load strobe rewrites the same word
    pulse_le(w, 4'b0010, "R12");

    // R8: divide value of 1 is stored and flagged; flag survives a legal write
    send(mkref(2'b00, 1'b0, 1'b0, 1'b0, 15'd1, 2'b00), "R8");
    send(mkref(2'b00, 1'b0, 1'b0, 1'b0, 15'd50, 2'b00), "R8");

    // R7: mid-run reset clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) sh[i] = '0;
    exp_bad = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R7");

    // R8: main reference of zero also raises the flag
    send(mkref(2'b00, 1'b0, 1'b0, 1'b0, 15'd0, 2'b10), "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule